// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Configuration Controls

This block is the test access port of a chip. A standard sixteen-state controller is clocked by `tck` and steered by `tms`. It feeds a 10-bit instruction register. The active instruction chooses which data register sits between `tdi` and `tdo`. The choices are a one-bit bypass stage, a 32-bit identification word fixed by a parameter, a 32-bit user word taken from an input, or a boundary register whose width is a parameter.

Some instructions also act on the pads:
- One releases every controlled output to high impedance.
- One freezes the outputs at the boundary register's latched values.
- One drives the outputs from that register while their inputs are being captured.

Two further instructions reach the configuration logic. One emits a single-cycle reconfiguration request. The other raises a hold request that lasts until the configuration logic reports completion. Pad cells and configuration circuitry live outside the block and see only these strobes and levels.

Top module: `jtag_tap_top`

## Requirements
- R1: The controller follows the standard sixteen-state sequence on rising `tck`. Five consecutive cycles with `tms` high reach Test-Logic-Reset from any state. `trst_n` low at a rising edge forces Test-Logic-Reset.
- R2: After reset, and in every cycle spent in Test-Logic-Reset, the active instruction is the identification opcode 10'b00_0000_0110. No pad override is asserted.
- R3: Capture-IR loads 10'b00_0000_0001 into the instruction shift stage. That stage shifts in from `tdi`, and its LSB comes out first. The active instruction changes only on leaving Update-IR, or in Test-Logic-Reset.
- R4: Register selection by opcode. 10'b00_0000_0000 (external test) and 10'b00_0000_0101 (sample/preload) select the boundary register. 10'b00_0000_0110 selects the identification word. 10'b00_0000_0111 selects the user word. Every other code selects the bypass stage, including all-ones, 10'b00_0000_1011, 10'b00_0000_1010, 10'b00_0000_0001 and 10'b00_0000_1101.
- R5: The bypass stage captures 0. It passes `tdi` to `tdo` with one `tck` of delay.
- R6: Capture-DR loads `IDCODE_VAL`, `usercode_in` or `pin_in` into the selected register. Data registers shift in from `tdi`, and their LSB comes out first on `tdo`.
- R7: Leaving Update-DR copies the boundary shift stage to `pad_bsr_value`, but only when the boundary register is selected. Otherwise `pad_bsr_value` keeps its value.
- R8: `pad_tristate` is high exactly while 10'b00_0000_1011 is active. `pad_use_bsr` is high exactly while 10'b00_0000_0000 or 10'b00_0000_1010 is active.
- R9: Leaving Update-IR with 10'b00_0000_0001 in the shift stage raises `reconfig_pulse` for exactly one `tck` cycle.
- R10: Leaving Update-IR with 10'b00_0000_1101 in the shift stage sets `cfg_hold`. It stays set until `cfg_done` is high at a rising edge, or until `trst_n` is low.
- R11: `tdo` and `tdo_oe` change only on falling `tck`. `tdo_oe` is high only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising `tck` |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| usercode_in | input | 32 | User word captured for the user-code instruction |
| pin_in | input | BSR_W | Pad states captured into the boundary register |
| cfg_done | input | 1 | Reconfiguration finished, clears `cfg_hold` |
| pad_tristate | output | 1 | Release all controlled outputs to high impedance |
| pad_use_bsr | output | 1 | Drive controlled outputs from `pad_bsr_value` |
| pad_bsr_value | output | BSR_W | Latched boundary register contents |
| reconfig_pulse | output | 1 | One-cycle request to restart configuration |
| cfg_hold | output | 1 | Request to hold configuration status low |

## Verification
The hard part to show from the ports is that only four of the 1024 instruction codes lengthen the scan path, and only three touch the pads. Every other code, including the ones with configuration side effects, must act as plain bypass. The stimulus reaches this by loading each of the 1024 codes in turn through a full IR scan. Each load is followed by a 32-bit DR scan with a code-dependent pattern and code-dependent pin values. The expected stream is computed from the selected register's length and capture value, and is compared with what the block returns. The sticky hold request is driven into its set state and then released. Release comes once through the completion input and once through test reset.

// File: rtl/jtag_tap_pkg.sv
// Shared types for the test access port: controller states, opcodes,
// the decoded-instruction record and the state transition function.
// Assumes a fixed 10-bit instruction register.
package jtag_tap_pkg;

    localparam int IR_W = 10;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 10'h000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 10'h005;
    localparam logic [IR_W-1:0] OP_IDCODE  = 10'h006;
    localparam logic [IR_W-1:0] OP_USER    = 10'h007;
    localparam logic [IR_W-1:0] OP_CLAMP   = 10'h00A;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 10'h00B;
    localparam logic [IR_W-1:0] OP_RECONF  = 10'h001;
    localparam logic [IR_W-1:0] OP_CFGIO   = 10'h00D;
    localparam logic [IR_W-1:0] IR_CAPTURE = 10'h001;

    typedef enum logic [1:0] {DR_BYP, DR_ID, DR_USER, DR_BSR} dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    highz;
        logic    clamp;
        logic    extest;
    } ir_dec_t;

    // Map an opcode to its data register and pad controls; unknown codes act as bypass.
    function automatic ir_dec_t decode_op(input logic [IR_W-1:0] op);
        ir_dec_t d;
        d = '{sel: DR_BYP, highz: 1'b0, clamp: 1'b0, extest: 1'b0};
        case (op)
            OP_EXTEST: begin d.sel = DR_BSR; d.extest = 1'b1; end
            OP_SAMPLE: d.sel = DR_BSR;
            OP_IDCODE: d.sel = DR_ID;
            OP_USER:   d.sel = DR_USER;
            OP_CLAMP:  d.clamp = 1'b1;
            OP_HIGHZ:  d.highz = 1'b1;
            default:   ;
        endcase
        return d;
    endfunction

    // Standard controller transition for one rising edge.
    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_TLR:    n = m ? ST_TLR    : ST_RTI;
            ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UP_DR  : ST_PA_DR;
            ST_PA_DR:  n = m ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: n = m ? ST_UP_DR  : ST_SH_DR;
            ST_UP_DR:  n = m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UP_IR  : ST_PA_IR;
            ST_PA_IR:  n = m ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: n = m ? ST_UP_IR  : ST_SH_IR;
            default:   n = m ? ST_SEL_DR : ST_RTI;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
// Sixteen-state test controller clocked on rising tck.
// Assumes trst_n is synchronous to tck and active low.
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    // Advance the controller, or return it to Test-Logic-Reset on reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= tap_next(state, tms);
    end

endmodule

// File: rtl/jtag_tap_ir.sv
// Instruction shift stage, active instruction and the configuration
// strobes that fire on instruction update. Assumes the controller state
// comes from jtag_tap_fsm on the same clock.
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    input  logic            cfg_done,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_lsb,
    output logic            reconfig_pulse,
    output logic            cfg_hold
);

    logic [IR_W-1:0] ir_sh;

    // Capture the fixed pattern, then shift serially LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_sh <= IR_CAPTURE;
        else if (state == ST_CAP_IR) ir_sh <= IR_CAPTURE;
        else if (state == ST_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    // Hold the active instruction; the identification code is the reset choice.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_TLR) ir_q <= OP_IDCODE;
        else if (state == ST_UP_IR)     ir_q <= ir_sh;
    end

    // Single-cycle reconfiguration request on its instruction's update.
    always_ff @(posedge tck) begin
        if (!trst_n) reconfig_pulse <= 1'b0;
        else         reconfig_pulse <= (state == ST_UP_IR) && (ir_sh == OP_RECONF);
    end

    // Sticky hold request, set on update, cleared by the completion input.
    always_ff @(posedge tck) begin
        if (!trst_n)                                       cfg_hold <= 1'b0;
        else if (state == ST_UP_IR && ir_sh == OP_CFGIO)   cfg_hold <= 1'b1;
        else if (cfg_done)                                 cfg_hold <= 1'b0;
    end

    assign ir_lsb = ir_sh[0];

endmodule

// File: rtl/jtag_tap_dr.sv
// Data registers: bypass stage, one 32-bit stage shared by the identification
// and user words, and the boundary register with its parallel latch.
// Assumes the register selection is stable for the whole DR scan.
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_W      = 8,
    parameter logic [31:0] IDCODE_VAL = 32'h0A5C_30DD
) (
    input  logic              tck,
    input  logic              trst_n,
    input  tap_state_e        state,
    input  logic              tdi,
    input  dr_sel_e           sel,
    input  logic [WORD_W-1:0] usercode_in,
    input  logic [BSR_W-1:0]  pin_in,
    output logic              dr_lsb,
    output logic [BSR_W-1:0]  bsr_par
);

    logic              byp_q;
    logic [WORD_W-1:0] word_sh;
    logic [BSR_W-1:0]  bsr_sh;
    logic [BSR_W-1:0]  bsr_shifted;

    assign bsr_shifted = (bsr_sh >> 1) | (BSR_W'(tdi) << (BSR_W - 1));

    // Bypass stage: capture zero, shift when selected.
    always_ff @(posedge tck) begin
        if (!trst_n)                                byp_q <= 1'b0;
        else if (state == ST_CAP_DR)                byp_q <= 1'b0;
        else if (state == ST_SH_DR && sel == DR_BYP) byp_q <= tdi;
    end

    // Word stage: load the identification or user word, then shift.
    always_ff @(posedge tck) begin
        if (!trst_n) word_sh <= '0;
        else if (state == ST_CAP_DR && sel == DR_ID)   word_sh <= IDCODE_VAL;
        else if (state == ST_CAP_DR && sel == DR_USER) word_sh <= usercode_in;
        else if (state == ST_SH_DR && (sel == DR_ID || sel == DR_USER))
            word_sh <= {tdi, word_sh[WORD_W-1:1]};
    end

    // Boundary shift stage: capture pad states, then shift.
    always_ff @(posedge tck) begin
        if (!trst_n)                                   bsr_sh <= '0;
        else if (state == ST_CAP_DR && sel == DR_BSR)  bsr_sh <= pin_in;
        else if (state == ST_SH_DR && sel == DR_BSR)   bsr_sh <= bsr_shifted;
    end

    // Boundary parallel latch, written on update of a boundary scan.
    always_ff @(posedge tck) begin
        if (!trst_n)                                  bsr_par <= '0;
        else if (state == ST_UP_DR && sel == DR_BSR)  bsr_par <= bsr_sh;
    end

    // Serial output of the selected register.
    always_comb begin
        case (sel)
            DR_BSR:          dr_lsb = bsr_sh[0];
            DR_ID, DR_USER:  dr_lsb = word_sh[0];
            default:         dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/jtag_tap_top.sv
// Test access port top: controller, instruction path, data registers,
// falling-edge serial output and decoded pad controls.
// Assumes tck is the only clock and trst_n is synchronous to it.
module jtag_tap_top
    import jtag_tap_pkg::*;
#(
    parameter int          BSR_W      = 8,
    parameter logic [31:0] IDCODE_VAL = 32'h0A5C_30DD
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [31:0]      usercode_in,
    input  logic [BSR_W-1:0] pin_in,
    input  logic             cfg_done,
    output logic             pad_tristate,
    output logic             pad_use_bsr,
    output logic [BSR_W-1:0] pad_bsr_value,
    output logic             reconfig_pulse,
    output logic             cfg_hold
);

    tap_state_e      state_q;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb;
    logic            dr_lsb;
    ir_dec_t         dec;

    jtag_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state_q)
    );

    jtag_tap_ir u_ir (
        .tck            (tck),
        .trst_n         (trst_n),
        .state          (state_q),
        .tdi            (tdi),
        .cfg_done       (cfg_done),
        .ir_q           (ir_q),
        .ir_lsb         (ir_lsb),
        .reconfig_pulse (reconfig_pulse),
        .cfg_hold       (cfg_hold)
    );

    assign dec = decode_op(ir_q);

    jtag_tap_dr #(
        .BSR_W      (BSR_W),
        .IDCODE_VAL (IDCODE_VAL)
    ) u_dr (
        .tck         (tck),
        .trst_n      (trst_n),
        .state       (state_q),
        .tdi         (tdi),
        .sel         (dec.sel),
        .usercode_in (usercode_in),
        .pin_in      (pin_in),
        .dr_lsb      (dr_lsb),
        .bsr_par     (pad_bsr_value)
    );

    // Retime serial output and its enable onto the falling edge.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state_q == ST_SH_DR) || (state_q == ST_SH_IR);
            tdo    <= (state_q == ST_SH_IR) ? ir_lsb :
                      (state_q == ST_SH_DR) ? dr_lsb : 1'b0;
        end
    end

    assign pad_tristate = dec.highz;
    assign pad_use_bsr  = dec.extest | dec.clamp;

endmodule

// File: rtl/jtag_tap_chk.sv
// Temporal checks on the test access port, bound into every instance of the top.
// Assumes it sees the controller state and active instruction of the top.
module jtag_tap_chk
    import jtag_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_q,
    input logic            cfg_done,
    input logic            cfg_hold,
    input logic            reconfig_pulse,
    input logic            tdo_oe,
    input logic            pad_tristate,
    input logic            pad_use_bsr
);

    a_r2_tlr_selects_idcode: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_TLR |=> ir_q == OP_IDCODE);

    a_r3_ir_held_outside_update: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UP_IR && state != ST_TLR) |=> $stable(ir_q));

    a_r8_overrides_exclusive: assert property (@(posedge tck) disable iff (!trst_n)
        !(pad_tristate && pad_use_bsr));

    a_r9_pulse_one_cycle: assert property (@(posedge tck) disable iff (!trst_n)
        reconfig_pulse |=> !reconfig_pulse);

    a_r10_hold_sticky: assert property (@(posedge tck) disable iff (!trst_n)
        (cfg_hold && !cfg_done) |=> cfg_hold);

    a_r10_done_releases: assert property (@(posedge tck) disable iff (!trst_n)
        (cfg_done && state != ST_UP_IR) |=> !cfg_hold);

    a_r11_oe_only_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_DR || state == ST_SH_IR));

endmodule

bind jtag_tap_top jtag_tap_chk u_chk (
    .tck            (tck),
    .trst_n         (trst_n),
    .state          (state_q),
    .ir_q           (ir_q),
    .cfg_done       (cfg_done),
    .cfg_hold       (cfg_hold),
    .reconfig_pulse (reconfig_pulse),
    .tdo_oe         (tdo_oe),
    .pad_tristate   (pad_tristate),
    .pad_use_bsr    (pad_use_bsr)
);

// File: tb/tb_jtag_tap_top.sv
// Sweeps all 1024 instruction codes, each followed by a 32-bit data scan,
// and compares against values computed from the requirements.
module tb_jtag_tap_top;

    localparam int          BW   = 8;
    localparam logic [31:0] IDV  = 32'h0A5C_30DD;
    localparam logic [31:0] USRV = 32'hC0DE_1234;

    logic          tck = 1'b0;
    logic          trst_n, tms, tdi, cfg_done;
    logic [31:0]   usercode_in;
    logic [BW-1:0] pin_in;
    logic          tdo, tdo_oe, pad_tristate, pad_use_bsr, reconfig_pulse, cfg_hold;
    logic [BW-1:0] pad_bsr_value;

    int n_checks = 0;
    int n_fails  = 0;
    logic stable_ok = 1'b1;
    logic oe_ok     = 1'b1;

    always #4 tck = ~tck;

    jtag_tap_top #(.BSR_W(BW), .IDCODE_VAL(IDV)) dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .usercode_in(usercode_in), .pin_in(pin_in), .cfg_done(cfg_done),
        .pad_tristate(pad_tristate), .pad_use_bsr(pad_use_bsr),
        .pad_bsr_value(pad_bsr_value), .reconfig_pulse(reconfig_pulse), .cfg_hold(cfg_hold)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // One tck cycle: sample tdo before the coming rising edge, then drive inputs.
    task automatic step(input logic m, input logic d, output logic o);
        @(negedge tck); #1;
        o = tdo;
        if (tdo_oe !== 1'b1 && m === 1'bx) oe_ok = 1'b0;
        tms = m;
        tdi = d;
    endtask

    task automatic settle();
        @(negedge tck); #1;
    endtask

    // Full IR scan from Run-Test/Idle back to Run-Test/Idle.
    task automatic scan_ir(input logic [9:0] code, output logic [9:0] cap);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 10; i++) begin
            step(i == 9, code[i], o);
            cap[i] = o;
            if (tdo_oe !== 1'b1) oe_ok = 1'b0;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    // Full 32-bit DR scan; also watches that tdo holds across rising edges (R11).
    task automatic scan_dr(input logic [31:0] pat, output logic [31:0] res);
        logic o;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 32; i++) begin
            step(i == 31, pat[i], o);
            res[i] = o;
            if (tdo_oe !== 1'b1) oe_ok = 1'b0;
            @(posedge tck); #1;
            if (tdo !== o) stable_ok = 1'b0;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    function automatic logic [31:0] expect_stream(input int len, input logic [31:0] cap, input logic [31:0] pat);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = (i < len) ? cap[i] : pat[(i - len) & 31];
        return r;
    endfunction

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [9:0]    cap;
        logic [31:0]   res, pat, capv, expv;
        logic [BW-1:0] bsr_model;
        logic          o;
        int            len;

        trst_n = 0; tms = 1; tdi = 0; cfg_done = 0;
        usercode_in = USRV; pin_in = '0;
        bsr_model = '0;
        repeat (3) settle();
        trst_n = 1;
        settle();

        // Reset state (R1, R2, R11)
        chk(tdo_oe == 0, "R11 tdo_oe after reset", tdo_oe, 0);
        chk(!pad_tristate && !pad_use_bsr, "R2 pads released after reset", {pad_tristate, pad_use_bsr}, 0);
        chk(!reconfig_pulse && !cfg_hold, "R9 R10 strobes idle after reset", {reconfig_pulse, cfg_hold}, 0);
        step(0, 0, o);
        scan_dr(32'h1357_9BDF, res);
        chk(res == IDV, "R2 identification selected after reset", res, IDV);

        // Sweep of every instruction code (R3-R10)
        for (int c = 0; c < 1024; c++) begin
            logic [9:0] code;
            code = c[9:0];
            scan_ir(code, cap);
            chk(cap == 10'h001, "R3 IR capture pattern", cap, 10'h001);
            settle();
            chk(reconfig_pulse == (code == 10'h001), "R9 reconfig pulse high", reconfig_pulse, code == 10'h001);
            chk(cfg_hold == (code == 10'h00D), "R10 hold set by its opcode", cfg_hold, code == 10'h00D);
            chk(pad_tristate == (code == 10'h00B), "R8 tristate decode", pad_tristate, code == 10'h00B);
            chk(pad_use_bsr == (code == 10'h000 || code == 10'h00A), "R8 boundary drive decode",
                pad_use_bsr, code == 10'h000 || code == 10'h00A);
            settle();
            chk(reconfig_pulse == 0, "R9 reconfig pulse lasts one cycle", reconfig_pulse, 0);

            pin_in = code[7:0] ^ 8'h5A;
            pat = {code, 12'hA5C, ~code};
            if (code == 10'h000 || code == 10'h005) begin len = BW; capv = 32'(pin_in); end
            else if (code == 10'h006)               begin len = 32; capv = IDV; end
            else if (code == 10'h007)               begin len = 32; capv = USRV; end
            else                                    begin len = 1;  capv = 0; end
            scan_dr(pat, res);
            expv = expect_stream(len, capv, pat);
            chk(res == expv, "R4 R5 R6 scan stream for selected register", res, expv);
            if (len == BW) bsr_model = pat[31 -: BW];
            settle();
            chk(pad_bsr_value == bsr_model, "R7 boundary latch", pad_bsr_value, bsr_model);

            if (code == 10'h00D) begin
                cfg_done = 1; settle(); cfg_done = 0; settle();
                chk(cfg_hold == 0, "R10 hold released by cfg_done", cfg_hold, 0);
            end
        end
        chk(stable_ok, "R11 tdo steady across rising edges", stable_ok, 1);
        chk(oe_ok, "R11 tdo_oe high while shifting", oe_ok, 1);
        settle();
        chk(tdo_oe == 0, "R11 tdo_oe low outside shift", tdo_oe, 0);

        // Five TMS highs reach Test-Logic-Reset and restore identification (R1, R2)
        scan_ir(10'h00B, cap);
        settle();
        chk(pad_tristate == 1, "R8 tristate active before reset walk", pad_tristate, 1);
        for (int k = 0; k < 5; k++) step(1, 0, o);
        settle(); settle();
        chk(pad_tristate == 0, "R1 R2 tms walk releases pads", pad_tristate, 0);
        step(0, 0, o);
        scan_dr(32'h0F0F_1234, res);
        chk(res == IDV, "R1 R2 identification after tms walk", res, IDV);

        // Test reset clears hold and clamp (R1, R10)
        scan_ir(10'h00D, cap);
        settle();
        chk(cfg_hold == 1, "R10 hold set before test reset", cfg_hold, 1);
        trst_n = 0; settle(); settle(); trst_n = 1; settle();
        chk(cfg_hold == 0, "R10 test reset clears hold", cfg_hold, 0);
        step(0, 0, o);
        scan_ir(10'h00A, cap);
        settle();
        chk(pad_use_bsr == 1, "R8 clamp drives from boundary latch", pad_use_bsr, 1);
        trst_n = 0; settle(); settle(); trst_n = 1; settle();
        chk(pad_use_bsr == 0 && pad_tristate == 0, "R1 R2 test reset releases pads",
            {pad_use_bsr, pad_tristate}, 0);

        finish_run();
    end

endmodule